// File: doc/BRIEF.md
# Bit-Serial Multiplier-Free FIR Inner Product

This block computes a fixed-coefficient FIR result, the sum of every coefficient times its matching stored sample, with no multiplier. The most recent `N_TAPS` samples sit in a shift register. A result is built over `SAMPLE_W` clock cycles. In each cycle the block takes the bit at one position from every stored sample and uses that group of bits as the address of a small constant table. The table holds the sum of every subset of the coefficients. Its output is added into an accumulator with the weight of that bit position.

The coefficients are fixed when the block is built. They are packed into one parameter vector. The table is computed when the design is elaborated, so no data file is needed. The caller offers a sample with `in_valid` while `in_ready` is high. After a fixed number of cycles the block pulses `out_valid` with the new result. Samples are unsigned.

Top module: `da_fir`

## Requirements
- R1: While `rst_n` is low and after its release, `in_ready` is 1, `out_valid` is 0 and `out_result` is 0.
- R2: When `out_valid` is high, `out_result` equals the sum over n from 0 to `N_TAPS`-1 of coefficient n times tap n. Coefficient n is `COEFS[n*COEF_W +: COEF_W]`, unsigned. Tap 0 is the sample accepted last, and tap n is the one accepted n acceptances earlier.
- R3: `out_valid` goes high in the cycle that begins exactly `SAMPLE_W` clock edges after the edge at which a sample was accepted.
- R4: A sample is accepted only at an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the accepting edge until `out_valid` rises. While `in_ready` is low, `in_valid` and `in_sample` have no effect.
- R5: `out_valid` is high for exactly one cycle per accepted sample, and `in_ready` is high in that cycle.
- R6: After reset, taps not yet filled by an accepted sample count as zero. The taps move by one position only when a sample is accepted.
- R7: The output is `SAMPLE_W + COEF_W + ceil(log2 N_TAPS)` bits wide. It gives the exact sum without overflow when every tap holds all ones.
- R8: `out_result` changes only in a cycle in which `out_valid` is high, and it holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered on `in_sample` |
| in_sample | input | SAMPLE_W | Unsigned input sample |
| in_ready | output | 1 | The block can accept a sample at the next edge |
| out_valid | output | 1 | One-cycle pulse: `out_result` holds a new result |
| out_result | output | SAMPLE_W+COEF_W+clog2(N_TAPS) | Filter result |

## Verification
The bench first sends one lone sample after reset. If the taps were not cleared, or if they shifted on offers that were not accepted, this result would pick up stray terms. Long runs of all-ones samples drive the accumulator to its largest value. A design with the accumulator too narrow, or with the table entries too narrow, would return a result that wraps modulo a power of two. A run of zeros checks that the table entry at address zero adds nothing. Throughout the run, `in_valid` is held high while the block is busy, so a design that accepted samples early, or weighted the bit slices in the wrong order, would show up as shifted taps, a wrong latency or a wrong sum.

// File: rtl/da_fir_pkg.sv
// Shared definitions for the bit-serial FIR.
// Assumes: nothing beyond IEEE 1800-2017.
package da_fir_pkg;

    // Sequencer state: waiting for a sample, or walking the bit slices.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } da_state_e;

endpackage

// File: rtl/da_fir_taps.sv
// Sample history for the FIR, with a bit-column read port.
// Holds the last N_TAPS accepted samples. Entry 0 is the newest.
// The history shifts only when shift_en is high. Reset clears every entry.
// col_bits[n] is bit bit_sel of entry n.
// Assumes: N_TAPS >= 2, and bit_sel < SAMPLE_W.
module da_fir_taps #(
    parameter int N_TAPS   = 4,
    parameter int SAMPLE_W = 8,
    localparam int SEL_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [SAMPLE_W-1:0] din,
    input  logic [SEL_W-1:0]    bit_sel,
    output logic [N_TAPS-1:0]   col_bits
);

    logic [SAMPLE_W-1:0] hist [N_TAPS];

    // Shift a new sample in at entry 0 when one is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < N_TAPS; n++) hist[n] <= '0;
        end else if (shift_en) begin
            hist[0] <= din;
            for (int n = 1; n < N_TAPS; n++) hist[n] <= hist[n-1];
        end
    end

    // Take the same bit position from every entry to form the table address.
    for (genvar n = 0; n < N_TAPS; n++) begin : g_col
        assign col_bits[n] = hist[n][bit_sel];
    end

endmodule

// File: rtl/da_fir_table.sv
// Constant partial-sum table of the coefficients.
// Entry k is the sum of every coefficient n for which bit n of k is 1.
// The entries are computed at elaboration, so no file is read.
// Assumes: N_TAPS >= 2, and the coefficients are unsigned.
module da_fir_table #(
    parameter int                      N_TAPS = 4,
    parameter int                      COEF_W = 8,
    parameter logic [N_TAPS*COEF_W-1:0] COEFS = '0,
    localparam int TBL_W = COEF_W + $clog2(N_TAPS),
    localparam int DEPTH = 1 << N_TAPS
) (
    input  logic [N_TAPS-1:0] addr,
    output logic [TBL_W-1:0]  data
);

    // Sum of the coefficients selected by the bits of k.
    function automatic logic [TBL_W-1:0] subset_sum(input int k);
        logic [TBL_W-1:0] s;
        s = '0;
        for (int n = 0; n < N_TAPS; n++) begin
            if (k[n])
                s = s + {{(TBL_W-COEF_W){1'b0}}, COEFS[n*COEF_W +: COEF_W]};
        end
        return s;
    endfunction

    logic [TBL_W-1:0] rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        assign rom[k] = subset_sum(k);
    end

    // Combinational lookup.
    assign data = rom[addr];

endmodule

// File: rtl/da_fir_seq.sv
// Bit-slice sequencer and shift accumulator.
// After start, it walks the bit positions from the most significant to the
// least significant, one per cycle. In each cycle it doubles the running sum
// and adds the table output. After the last slice it registers the result
// and pulses done.
// Assumes: tbl_data matches bit_sel in the same cycle (the lookup is
// combinational).
module da_fir_seq #(
    parameter int SAMPLE_W = 8,
    parameter int TBL_W    = 10,
    localparam int SEL_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1,
    localparam int ACC_W   = SAMPLE_W + TBL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TBL_W-1:0] tbl_data,
    output logic [SEL_W-1:0] bit_sel,
    output logic             idle,
    output logic             done,
    output logic [ACC_W-1:0] result
);
    import da_fir_pkg::*;

    localparam logic [SEL_W-1:0] TOP_BIT = SEL_W'(SAMPLE_W - 1);

    da_state_e        state;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;

    // Double the running sum, then add the current slice's partial sum.
    assign acc_next = {acc[ACC_W-2:0], 1'b0} + {{SAMPLE_W{1'b0}}, tbl_data};

    // Start a conversion, step through the slices and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_sel <= '0;
            acc     <= '0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_RUN;
                        bit_sel <= TOP_BIT;
                        acc     <= '0;
                    end
                end
                ST_RUN: begin
                    acc <= acc_next;
                    if (bit_sel == '0) begin
                        state  <= ST_IDLE;
                        result <= acc_next;
                        done   <= 1'b1;
                    end else begin
                        bit_sel <= bit_sel - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle = (state == ST_IDLE);

endmodule

// File: rtl/da_fir.sv
// Multiplier-free FIR inner product, computed one bit slice per cycle.
// It accepts one unsigned sample when in_valid and in_ready are both high.
// The result follows SAMPLE_W cycles later as a one-cycle out_valid pulse.
// Coefficients are packed, tap n at COEFS[n*COEF_W +: COEF_W].
// Assumes: N_TAPS >= 2 and SAMPLE_W >= 2.
module da_fir #(
    parameter int                       N_TAPS   = 4,
    parameter int                       SAMPLE_W = 8,
    parameter int                       COEF_W   = 8,
    parameter logic [N_TAPS*COEF_W-1:0] COEFS    = 32'hFF_C8_11_03,
    localparam int TBL_W = COEF_W + $clog2(N_TAPS),
    localparam int OUT_W = SAMPLE_W + TBL_W,
    localparam int SEL_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                in_ready,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_result
);

    logic              accept;
    logic [SEL_W-1:0]  bit_sel;
    logic [N_TAPS-1:0] col_bits;
    logic [TBL_W-1:0]  tbl_data;

    // A sample is taken only while the sequencer is idle.
    assign accept = in_valid & in_ready;

    da_fir_taps #(
        .N_TAPS   (N_TAPS),
        .SAMPLE_W (SAMPLE_W)
    ) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_sample),
        .bit_sel  (bit_sel),
        .col_bits (col_bits)
    );

    da_fir_table #(
        .N_TAPS (N_TAPS),
        .COEF_W (COEF_W),
        .COEFS  (COEFS)
    ) u_table (
        .addr (col_bits),
        .data (tbl_data)
    );

    da_fir_seq #(
        .SAMPLE_W (SAMPLE_W),
        .TBL_W    (TBL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .tbl_data (tbl_data),
        .bit_sel  (bit_sel),
        .idle     (in_ready),
        .done     (out_valid),
        .result   (out_result)
    );

endmodule

// File: rtl/da_fir_checker.sv
// Port-level protocol checks for da_fir, attached with bind.
// A counter tracks the cycles since the last acceptance, so the latency
// window does not depend on a parameter-sized delay.
module da_fir_checker #(
    parameter int SAMPLE_W = 8,
    parameter int OUT_W    = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_result
);

    localparam int CW = $clog2(SAMPLE_W + 2) + 1;

    logic [CW-1:0] since_acc;

    // Count the edges since the last accepted sample. Zero means none is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                     since_acc <= '0;
        else if (in_valid && in_ready)  since_acc <= CW'(1);
        else if (out_valid)             since_acc <= '0;
        else if (since_acc != '0)       since_acc <= since_acc + 1'b1;
    end

    // R3: the result appears exactly SAMPLE_W edges after acceptance.
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_acc == CW'(SAMPLE_W + 1)));

    // R4: in_ready stays low while a conversion is pending.
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_acc != '0) && !out_valid) |-> !in_ready);

    // R4: an acceptance drops in_ready at the next edge.
    a_r4_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5: one-cycle pulse, with in_ready high in that cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r5_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    // R8: the result changes only together with out_valid.
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_result) |-> out_valid);

endmodule

bind da_fir da_fir_checker #(
    .SAMPLE_W (SAMPLE_W),
    .OUT_W    (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tb_da_fir.sv
`timescale 1ns/1ps
// Bench for da_fir. A behavioural model of the history and the handshake is
// compared with the outputs at every falling edge.
module tb_da_fir;

    localparam int N_TAPS   = 4;
    localparam int SAMPLE_W = 8;
    localparam int COEF_W   = 8;
    localparam logic [N_TAPS*COEF_W-1:0] COEFS = 32'hFF_C8_11_03;
    localparam int OUT_W    = SAMPLE_W + COEF_W + $clog2(N_TAPS);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [SAMPLE_W-1:0] in_sample = '0;
    logic                in_ready;
    logic                out_valid;
    logic [OUT_W-1:0]    out_result;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    // Reference model state: the expected outputs at the next falling edge.
    longint hist [N_TAPS];
    longint pend_val  = 0;
    int     busy_left = 0;
    bit     exp_ready = 1'b1;
    bit     exp_valid = 1'b0;
    longint exp_res   = 0;

    always #2.5 clk = ~clk;

    da_fir #(
        .N_TAPS   (N_TAPS),
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .COEFS    (COEFS)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint coef(input int n);
        return longint'(COEFS[n*COEF_W +: COEF_W]);
    endfunction

    // Compare at every falling edge, then advance the model to the next edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(in_ready == exp_ready, "R4 in_ready", in_ready, exp_ready);
            check(out_valid == exp_valid, "R3/R5 out_valid", out_valid, exp_valid);
            if (exp_valid)
                check(longint'(out_result) == exp_res, "R2/R6/R7 result", out_result, exp_res);
            else
                check(longint'(out_result) == exp_res, "R8 result held", out_result, exp_res);

            exp_valid = 1'b0;
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    exp_valid = 1'b1;
                    exp_ready = 1'b1;
                    exp_res   = pend_val;
                end
            end else if (in_valid && exp_ready) begin
                for (int n = N_TAPS - 1; n > 0; n--) hist[n] = hist[n-1];
                hist[0] = longint'(in_sample);
                pend_val = 0;
                for (int n = 0; n < N_TAPS; n++) pend_val += coef(n) * hist[n];
                busy_left = SAMPLE_W;
                exp_ready = 1'b0;
            end
        end
    end

    task automatic drive(input bit v, input logic [SAMPLE_W-1:0] d);
        @(posedge clk);
        #1;
        in_valid  = v;
        in_sample = d;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        for (int n = 0; n < N_TAPS; n++) hist[n] = 0;
        // R1: reset state, driven with in_valid high to show it has no effect.
        in_valid = 1'b1;
        in_sample = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_result == '0, "R1 result in reset", out_result, 0);
        drive(1'b0, '0);
        rst_n = 1'b1;
        // R6: a lone sample after reset gives only coefficient 0 times it.
        drive(1'b1, 8'd5);
        drive(1'b0, 8'd0);
        repeat (20) drive(1'b0, 8'hAA);
        // R4: offers held high while busy must be ignored.
        for (int i = 0; i < 40; i++) drive(1'b1, 8'(i * 37));
        // R7: runs of all ones reach the largest sum.
        repeat (60) drive(1'b1, 8'hFF);
        // Zeros: table entry 0.
        repeat (50) drive(1'b1, 8'h00);
        // Random mix with edge values.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            drive($urandom_range(0, 1) == 1,
                  (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom));
        end
        drive(1'b0, '0);
        repeat (SAMPLE_W + 4) drive(1'b0, '0);
        @(negedge clk);
        finished = 1'b1;
        report();
    end

endmodule